// File: doc/BRIEF.md
# Slow Timekeeping Clock Source Selector

This block chooses where the slow timekeeping tick of a chip comes from. Two candidate sources arrive as single-cycle enable strobes in the system clock domain: one from an external low-frequency crystal, one from an internal RC oscillator. The external strobe is passed straight through. The internal strobe first goes through a fixed divider, set at build time, and then through a divider that software programs with a 5-bit value N, for a division by N+1. The chosen strobe comes out as `slow_tick`. A copy of it that software can gate goes to an output pin.

Software controls the block through a small write port with three registers. Writes to the control register only take effect when the upper half-word holds a key, so a stray store cannot retarget the timebase. The prescaler register and the pin-gating register take no key. If the external oscillator is reported as failing, the block falls back to the internal source by itself, unless software has disabled the fallback. A change of source is held back until the path that is currently active finishes a slow tick, so no shortened period is produced.

Top module: `lsclk_select`

## Requirements
- R1: A write to the control register (address 0) changes it only when `reg_wdata[31:16]` equals 16'h16AA. Any other control write leaves the register unchanged.
- R2: Control readback `ctrl_rd` carries the source select in bit 0 (0 = internal RC, 1 = external), the oscillator enable in bit 4 and the fallback disable in bit 15. All other bits read 0. `src_ext` shows which source currently drives `slow_tick`.
- R3: While the external source is active, each `ext_tick` strobe produces exactly one `slow_tick` pulse one cycle later, with no division.
- R4: While the internal source is active, one `slow_tick` is produced per FIXED_DIV×(N+1) `int_tick` strobes. N is `reg_wdata[4:0]` written to address 1, and no key is needed. If N is lowered below the current count, the next fixed-divider output produces a tick.
- R5: When bit 15 is 0 and `ext_fail` is high, bit 0 reads back as 0 in the next cycle. While `ext_fail` stays high, the active source becomes internal one cycle after that, without waiting for a tick.
- R6: When bit 15 is 1, `ext_fail` has no effect on bit 0 or on the active source. The output `ext_osc_en` follows bit 4.
- R7: Bit 0 of address 2 gates the pin copy. `pin_tick` equals `slow_tick` when the gate is 1 and stays 0 when it is 0. `gate_rd` reads the gate back.
- R8: A requested source change without a failure takes effect in the same cycle as a `slow_tick` issued by the old source. The internal divider restarts from zero whenever the internal path becomes active.
- R9: After reset the internal source is active, N is 0, the control and gate registers are 0, and no tick is output.
- R10: Writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | Strobe from the external crystal path |
| int_tick | input | 1 | Strobe from the internal RC oscillator |
| ext_fail | input | 1 | External oscillator failure indication |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 prescaler, 2 pin gate |
| reg_wdata | input | 32 | Write data, including the key half-word |
| slow_tick | output | 1 | Selected, divided slow tick |
| pin_tick | output | 1 | Gated copy of the slow tick for a pin |
| src_ext | output | 1 | 1 when the external source is active |
| ext_osc_en | output | 1 | External oscillator enable (control bit 4) |
| ctrl_rd | output | 16 | Control register readback |
| presc_rd | output | PRESC_W | Programmable prescaler readback |
| gate_rd | output | 1 | Pin gate readback |

## Verification
The bench builds the block with FIXED_DIV = 4 and PRESC_W = 5. With these values a full internal period lasts between 4 and 128 strobes, so many periods fit into a short run. This includes the largest prescaler value and a prescaler that is lowered while a count is in progress. The small fixed divider also lets the bench complete switches between sources within a few dozen cycles. This covers switches held back to a tick boundary, fallback on failure, and fallback blocked by bit 15.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_PRESC = 2'd1,
    ADDR_GATE  = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  localparam int SEL_BIT    = 0;
  localparam int OSC_EN_BIT = 4;
  localparam int NOFB_BIT   = 15;

  typedef struct packed {
    logic no_fb;
    logic osc_en;
    logic sel_ext;
  } ctrl_t;

endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
  import lsclk_pkg::*;
#(
  parameter logic [15:0] KEY     = 16'h16AA,
  parameter int          PRESC_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               ext_fail,
  output ctrl_t              ctrl_q,
  output logic [PRESC_W-1:0] presc_q,
  output logic               gate_q
);

  logic  key_ok;
  ctrl_t ctrl_nxt;
  logic  unused_wbits;

  assign key_ok       = (reg_wdata[31:16] == KEY);
  assign unused_wbits = ^reg_wdata;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (reg_wr && reg_addr == ADDR_CTRL && key_ok) begin
      ctrl_nxt.no_fb   = reg_wdata[NOFB_BIT];
      ctrl_nxt.osc_en  = reg_wdata[OSC_EN_BIT];
      ctrl_nxt.sel_ext = reg_wdata[SEL_BIT];
    end
    if (ext_fail && !ctrl_nxt.no_fb) ctrl_nxt.sel_ext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      gate_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nxt;
      if (reg_wr && reg_addr == ADDR_PRESC) presc_q <= reg_wdata[PRESC_W-1:0];
      if (reg_wr && reg_addr == ADDR_GATE)  gate_q  <= reg_wdata[0];
    end
  end

endmodule

// File: rtl/lsclk_int_div.sv
module lsclk_int_div #(
  parameter int FIXED_DIV = 32,
  parameter int PRESC_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               int_tick,
  input  logic [PRESC_W-1:0] presc,
  output logic               fire
);

  logic stage1;

  generate
    if (FIXED_DIV == 1) begin : g_no_fixed
      assign stage1 = int_tick & ~clr;
    end else begin : g_fixed
      localparam int FW = $clog2(FIXED_DIV);
      localparam logic [FW-1:0] FLAST = FW'(FIXED_DIV - 1);
      logic [FW-1:0] fcnt;

      assign stage1 = int_tick & ~clr & (fcnt == FLAST);

      always_ff @(posedge clk) begin
        if (rst || clr)    fcnt <= '0;
        else if (int_tick) fcnt <= stage1 ? '0 : fcnt + 1'b1;
      end
    end
  endgenerate

  logic [PRESC_W-1:0] pcnt;

  assign fire = stage1 & (pcnt >= presc);

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (stage1) pcnt <= fire ? '0 : pcnt + 1'b1;
  end

endmodule

// File: rtl/lsclk_switch.sv
module lsclk_switch (
  input  logic clk,
  input  logic rst,
  input  logic sel_target,
  input  logic ext_tick,
  input  logic ext_fail,
  input  logic int_fire,
  input  logic gate,
  output logic act_ext,
  output logic slow_tick,
  output logic pin_tick
);

  logic cur_fire;
  logic may_switch;

  assign cur_fire   = act_ext ? ext_tick : int_fire;
  assign may_switch = cur_fire | (act_ext & ext_fail);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_ext   <= 1'b0;
      slow_tick <= 1'b0;
      pin_tick  <= 1'b0;
    end else begin
      slow_tick <= cur_fire;
      pin_tick  <= cur_fire & gate;
      if (act_ext != sel_target && may_switch) act_ext <= sel_target;
    end
  end

endmodule

// File: rtl/lsclk_select.sv
module lsclk_select
  import lsclk_pkg::*;
#(
  parameter int          FIXED_DIV = 32,
  parameter int          PRESC_W   = 5,
  parameter logic [15:0] KEY       = 16'h16AA
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_tick,
  input  logic               int_tick,
  input  logic               ext_fail,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic               slow_tick,
  output logic               pin_tick,
  output logic               src_ext,
  output logic               ext_osc_en,
  output logic [15:0]        ctrl_rd,
  output logic [PRESC_W-1:0] presc_rd,
  output logic               gate_rd
);

  ctrl_t ctrl_q;
  logic  int_fire;

  lsclk_regs #(.KEY(KEY), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ext_fail(ext_fail),
    .ctrl_q(ctrl_q), .presc_q(presc_rd), .gate_q(gate_rd)
  );

  lsclk_int_div #(.FIXED_DIV(FIXED_DIV), .PRESC_W(PRESC_W)) u_div (
    .clk(clk), .rst(rst), .clr(src_ext), .int_tick(int_tick),
    .presc(presc_rd), .fire(int_fire)
  );

  lsclk_switch u_sw (
    .clk(clk), .rst(rst), .sel_target(ctrl_q.sel_ext), .ext_tick(ext_tick),
    .ext_fail(ext_fail), .int_fire(int_fire), .gate(gate_rd),
    .act_ext(src_ext), .slow_tick(slow_tick), .pin_tick(pin_tick)
  );

  assign ext_osc_en = ctrl_q.osc_en;

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[SEL_BIT]    = ctrl_q.sel_ext;
    ctrl_rd[OSC_EN_BIT] = ctrl_q.osc_en;
    ctrl_rd[NOFB_BIT]   = ctrl_q.no_fb;
  end

endmodule

// File: rtl/lsclk_select_chk.sv
module lsclk_select_chk #(
  parameter logic [15:0] KEY = 16'h16AA
) (
  input logic        clk,
  input logic        rst,
  input logic        ext_tick,
  input logic        ext_fail,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        slow_tick,
  input logic        pin_tick,
  input logic        src_ext,
  input logic [15:0] ctrl_rd,
  input logic        gate_rd
);

  // R1: a keyless control write with no failure present changes nothing
  a_r1_key_guard: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[31:16] != KEY && !ext_fail)
      |=> $stable(ctrl_rd));

  // R3: an external strobe while external is active yields a tick
  a_r3_ext_pass: assert property (@(posedge clk) disable iff (rst)
    (src_ext && ext_tick) |=> slow_tick);

  // R5: failure with fallback enabled clears the select bit
  a_r5_fallback: assert property (@(posedge clk) disable iff (rst)
    (ext_fail && !ctrl_rd[15] && !(reg_wr && reg_addr == 2'd0)) |=> !ctrl_rd[0]);

  // R6: fallback disabled keeps the external select through a failure
  a_r6_no_fallback: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd[15] && ctrl_rd[0] && !(reg_wr && reg_addr == 2'd0)) |=> ctrl_rd[0]);

  // R7: the pin copy only pulses with the slow tick and an open gate
  a_r7_pin_gate: assert property (@(posedge clk) disable iff (rst)
    pin_tick |-> (slow_tick && $past(gate_rd)));

  // R8: a source change without failure coincides with a tick
  a_r8_boundary: assert property (@(posedge clk) disable iff (rst)
    ((src_ext != $past(src_ext)) && !($past(src_ext) && $past(ext_fail)))
      |-> slow_tick);

endmodule

bind lsclk_select lsclk_select_chk #(.KEY(KEY)) u_chk (
  .clk(clk), .rst(rst), .ext_tick(ext_tick), .ext_fail(ext_fail),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .slow_tick(slow_tick), .pin_tick(pin_tick), .src_ext(src_ext),
  .ctrl_rd(ctrl_rd), .gate_rd(gate_rd)
);

// File: tb/lsclk_select_bench.sv
module lsclk_select_bench;

  localparam int FIX = 4;
  localparam int PW  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_tick = 0, int_tick = 0, ext_fail = 0, reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic slow_tick, pin_tick, src_ext, ext_osc_en, gate_rd;
  logic [15:0] ctrl_rd;
  logic [PW-1:0] presc_rd;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lsclk_select #(.FIXED_DIV(FIX), .PRESC_W(PW), .KEY(16'h16AA)) u_lsclk_select (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .int_tick(int_tick),
    .ext_fail(ext_fail), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .slow_tick(slow_tick), .pin_tick(pin_tick),
    .src_ext(src_ext), .ext_osc_en(ext_osc_en), .ctrl_rd(ctrl_rd),
    .presc_rd(presc_rd), .gate_rd(gate_rd)
  );

  // Behavioural reference model, advanced on every rising edge
  int m_fc, m_pc, m_n;
  bit m_act, m_sel, m_en, m_byp, m_gate, e_slow, e_pin;

  always @(posedge clk) begin : model
    bit f1, f2, cf;
    if (rst) begin
      m_fc = 0; m_pc = 0; m_n = 0; m_act = 0; m_sel = 0; m_en = 0;
      m_byp = 0; m_gate = 0; e_slow = 0; e_pin = 0;
    end else begin
      f1 = 0; f2 = 0;
      if (!m_act) begin
        if (int_tick) begin
          if (m_fc == FIX - 1) begin f1 = 1; m_fc = 0; end
          else m_fc = m_fc + 1;
        end
        if (f1) begin
          if (m_pc >= m_n) begin f2 = 1; m_pc = 0; end
          else m_pc = m_pc + 1;
        end
      end else begin
        m_fc = 0; m_pc = 0;
      end
      cf = m_act ? ext_tick : f2;
      e_slow = cf;
      e_pin = cf && m_gate;
      if (m_act != m_sel && (cf || (m_act && ext_fail))) m_act = m_sel;
      if (reg_wr && reg_addr == 2'd0 && reg_wdata[31:16] == 16'h16AA) begin
        m_sel = reg_wdata[0]; m_en = reg_wdata[4]; m_byp = reg_wdata[15];
      end
      if (reg_wr && reg_addr == 2'd1) m_n = int'(reg_wdata[4:0]);
      if (reg_wr && reg_addr == 2'd2) m_gate = reg_wdata[0];
      if (ext_fail && !m_byp) m_sel = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [15:0] ec;
    ec = {m_byp, 10'b0, m_en, 3'b0, m_sel};
    check(slow_tick == e_slow, "R3 R4", "slow_tick", slow_tick, e_slow);
    check(pin_tick == e_pin, "R7", "pin_tick", pin_tick, e_pin);
    check(src_ext == m_act, "R8", "src_ext", src_ext, m_act);
    check(ctrl_rd == ec, "R1 R2 R5", "ctrl_rd", ctrl_rd, ec);
    check(presc_rd == PW'(m_n), "R4", "presc_rd", presc_rd, m_n);
    check(gate_rd == m_gate, "R7", "gate_rd", gate_rd, m_gate);
    check(ext_osc_en == m_en, "R6", "ext_osc_en", ext_osc_en, m_en);
  endtask

  task automatic step(input bit it, input bit et, input bit ef);
    int_tick = it; ext_tick = et; ext_fail = ef;
    @(negedge clk);
    reg_wr = 0;
    compare_all();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(0, 0, 0);
  endtask

  task automatic run(input int n, input int pint, input int pext);
    for (int i = 0; i < n; i++)
      step($urandom_range(0, 99) < pint, $urandom_range(0, 99) < pext, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int t0, t1, k;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({slow_tick, pin_tick, src_ext, gate_rd} == 4'b0, "R9", "tick/src/gate", 0, 0);
    check(ctrl_rd == 16'h0 && presc_rd == 0, "R9", "ctrl/presc", ctrl_rd, 0);
    rst = 0;
    step(0, 0, 0);

    run(300, 50, 30);                       // R4 with N = 0
    wr(2'd1, 32'h0000_0003);
    wr(2'd2, 32'h0000_0001);
    run(300, 60, 20);

    // R4 spacing with constant strobes: FIX*(N+1) = 16
    k = 0; t0 = 0; t1 = 0;
    for (int i = 0; i < 100 && k < 3; i++) begin
      step(1, 0, 0);
      if (slow_tick) begin k++; t0 = t1; t1 = i; end
    end
    check(k == 3 && (t1 - t0) == 16, "R4", "tick spacing", t1 - t0, 16);

    // R1 wrong or missing key
    wr(2'd0, 32'h0000_8011);
    check(ctrl_rd == 16'h0, "R1", "no key", ctrl_rd, 0);
    wr(2'd0, 32'h16AB_0011);
    check(ctrl_rd == 16'h0, "R1", "wrong key", ctrl_rd, 0);

    // R10 address 3 ignored
    wr(2'd3, 32'hFFFF_FFFF);
    check(ctrl_rd == 16'h0 && presc_rd == 5'd3 && gate_rd, "R10", "regs", ctrl_rd, 0);

    // R2 and R8: request external, held until the internal tick
    wr(2'd0, 32'h16AA_0011);
    check(ctrl_rd == 16'h0011, "R2", "ctrl_rd fields", ctrl_rd, 16'h0011);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    check(src_ext == 0, "R8", "held before tick", src_ext, 0);
    for (int i = 0; i < 100 && !slow_tick; i++) step(1, 0, 0);
    check(slow_tick && src_ext, "R8", "switch at tick", src_ext, 1);

    run(200, 50, 30);                        // R3
    step(0, 1, 0);
    check(slow_tick == 1, "R3", "ext pass", slow_tick, 1);
    step(0, 0, 0);
    check(slow_tick == 0, "R3", "single pulse", slow_tick, 0);

    wr(2'd1, 32'h0000_001F);
    // R5 fallback
    step(0, 0, 1);
    check(ctrl_rd[0] == 0 && src_ext == 1, "R5", "select cleared", ctrl_rd[0], 0);
    step(0, 0, 1);
    check(src_ext == 0, "R5", "source internal", src_ext, 0);
    step(0, 0, 0);

    run(600, 90, 30);                        // R4 N = 31
    wr(2'd1, 32'h0000_0000);                 // R4 lowered mid-count
    run(200, 70, 30);

    // R6 fallback disabled
    wr(2'd0, 32'h16AA_8011);
    for (int i = 0; i < 100 && !src_ext; i++) step(1, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 1);
    check(ctrl_rd == 16'h8011 && src_ext && ext_osc_en, "R6", "fail ignored",
          ctrl_rd, 16'h8011);
    run(100, 40, 40);

    // R7 gate closed
    wr(2'd2, 32'h0000_0000);
    step(0, 1, 0);
    check(slow_tick && !pin_tick, "R7", "pin gated", pin_tick, 0);

    // R8 back to internal waits for an external tick
    wr(2'd0, 32'h16AA_8000);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    check(src_ext == 1, "R8", "held for ext tick", src_ext, 1);
    step(1, 1, 0);
    check(slow_tick && !src_ext, "R8", "switch at ext tick", src_ext, 0);
    run(300, 60, 30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule